// File: doc/BRIEF.md
# Programmable clock output controller

This block is the digital steering and gating stage of a two-output programmable clock generator. It receives a reference clock and a clock that an external loop has already synthesised. It runs a post divider that divides the reference by twice a 5-bit value. The main output is driven from one of three sources: the loop clock, the plain reference, or the divided reference. The secondary output carries either the plain reference or a copy of the main output.

All logic runs on one fast system clock. The reference, the loop clock and the control pin are synchronised into that domain and treated as oversampled data. Two configuration banks each hold a divider value, a main-source code and a secondary-source code. They are written through a simple parallel write port. A single control pin is given one role by `pin_role`: output enable, power-down, or bank select.

Output gating only changes while the gated source is low, so enabling and disabling never produce a shortened high pulse. A change of bank is deferred to the divider terminal count.

Top module: `refclk_steer`

## Requirements
- R1: Synchronous reset (`rst` high) holds both outputs low, makes bank 0 active, loads both banks with divider 1, the reference as main source and the reference as secondary source, and enables both outputs. After reset both outputs therefore run at the reference rate.
- R2: The main-source code selects the output: 0 selects the reference, 1 selects the loop clock, and 2 or 3 select the divided reference.
- R3: The divided reference has a period of 2*D reference periods and a high time of D reference periods, where D is the 5-bit divider value (1 to 31).
- R4: A divider value of 0 behaves as 1, so the divided reference runs at half the reference rate.
- R5: The secondary-source bit selects the secondary output: 0 selects the reference, and 1 selects a copy of the gated main output.
- R6: With `pin_role` 0 or 3 (output enable), a low pin holds the main output low. In that state the secondary output is also low when it copies the main output, and it keeps running when it sources the reference.
- R7: With `pin_role` 1 (power-down), a low pin holds both outputs low and stops and clears the divider. After the pin is released, the first divided high pulse starts only after the divider has counted D fresh reference periods.
- R8: An output's enable state changes only while that output's selected source is low. Every high pulse on an output therefore has the full length of its source pulse.
- R9: With `pin_role` 2 (bank select), the pin level picks bank 0 or bank 1. Each bank applies its own divider value, main source and secondary source, and the pin has no enabling effect.
- R10: A requested bank change takes effect only at a divider terminal count. Switching during operation never produces a high pulse shorter than the divided high time of either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, oversampled |
| loop_in | input | 1 | Synthesised loop clock, oversampled |
| ctl_pin | input | 1 | Multifunction control pin; idle level is 1 |
| pin_role | input | 2 | Role of ctl_pin: 0/3 enable, 1 power-down, 2 bank select |
| cfg_wr_en | input | 1 | Write strobe for a configuration bank |
| cfg_wr_bank | input | 1 | Bank written by the strobe |
| cfg_wr_div | input | 5 | Divider value to write |
| cfg_wr_main_sel | input | 2 | Main-source code to write |
| cfg_wr_aux_sel | input | 1 | Secondary-source bit to write |
| main_out | output | 1 | Registered main clock output |
| aux_out | output | 1 | Registered secondary clock output |

## Verification
The hardest condition to reach from the ports is a change that lands in the middle of a high pulse. Examples are an enable edge arriving while the reference is high, or a bank request arriving partway through a divided half period. The stimulus toggles the control pin on a period that shares no factor with the reference period, so the change points sweep across every phase of the source. Meanwhile a monitor records the shortest complete high pulse in the window. Count-based windows whose length is a multiple of every expected period cover the source codes, the divider values and the pin roles.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int DIV_W   = 5;
  localparam int N_BANKS = 2;
  localparam int BANK_W  = $clog2(N_BANKS);

  typedef enum logic [1:0] {
    MAIN_REF     = 2'd0,
    MAIN_LOOP    = 2'd1,
    MAIN_DIV     = 2'd2,
    MAIN_DIV_ALT = 2'd3
  } main_src_e;

  typedef enum logic {
    AUX_REF  = 1'b0,
    AUX_MAIN = 1'b1
  } aux_src_e;

  typedef enum logic [1:0] {
    ROLE_OE     = 2'd0,
    ROLE_PD     = 2'd1,
    ROLE_BANK   = 2'd2,
    ROLE_OE_ALT = 2'd3
  } pin_role_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    main_src_e        main_sel;
    aux_src_e         aux_sel;
  } bank_cfg_t;
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rcs_cfg_banks.sv
module rcs_cfg_banks
  import rcs_pkg::*;
#(
  parameter bank_cfg_t RST_CFG = '{div: DIV_W'(1), main_sel: MAIN_REF, aux_sel: AUX_REF}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  bank_cfg_t         wr_cfg,
  input  logic [BANK_W-1:0] rd_bank,
  output bank_cfg_t         rd_cfg
);
  bank_cfg_t mem [N_BANKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < N_BANKS; b++) mem[b] <= RST_CFG;
    end else if (wr_en) begin
      mem[wr_bank] <= wr_cfg;
    end
  end

  assign rd_cfg = mem[rd_bank];
endmodule

// File: rtl/rcs_post_div.sv
module rcs_post_div #(
  parameter int DIV_W = rcs_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ref_rise,
  input  logic [DIV_W-1:0] div,
  output logic             div_q,
  output logic             tc,
  output logic [DIV_W-1:0] cnt
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_eff;
  logic             last;

  assign div_eff = (div == '0) ? ONE : div;
  assign last    = (cnt >= div_eff - ONE);
  assign tc      = run && ref_rise && last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (ref_rise) begin
      if (last) begin
        cnt   <= '0;
        div_q <= ~div_q;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end
endmodule

// File: rtl/rcs_out_gate.sv
module rcs_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic want,
  output logic en_q,
  output logic pass,
  output logic out
);
  assign pass = src & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b1;
      out  <= 1'b0;
    end else begin
      if (!src) en_q <= want;
      out <= pass;
    end
  end
endmodule

// File: rtl/refclk_steer.sv
module refclk_steer
  import rcs_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [DIV_W-1:0] DIV_RST     = 5'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             loop_in,
  input  logic             ctl_pin,
  input  logic [1:0]       pin_role,
  input  logic             cfg_wr_en,
  input  logic             cfg_wr_bank,
  input  logic [DIV_W-1:0] cfg_wr_div,
  input  logic [1:0]       cfg_wr_main_sel,
  input  logic             cfg_wr_aux_sel,
  output logic             main_out,
  output logic             aux_out
);
  localparam int             IN_W     = 3;
  localparam logic [IN_W-1:0] IN_RST  = {1'b1, {(IN_W-1){1'b0}}};
  localparam bank_cfg_t      RST_CFG  = '{div: DIV_RST, main_sel: MAIN_REF, aux_sel: AUX_REF};

  // input synchronisation: {ctl, loop, ref}
  logic [IN_W-1:0] raw_in, sync_q;
  logic ref_s, loop_s, ctl_s, ref_d, ref_rise;

  assign raw_in = {ctl_pin, loop_in, ref_in};

  rcs_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_q)
  );

  assign ref_s  = sync_q[0];
  assign loop_s = sync_q[1];
  assign ctl_s  = sync_q[2];

  always_ff @(posedge clk) begin
    if (rst) ref_d <= 1'b0;
    else     ref_d <= ref_s;
  end
  assign ref_rise = ref_s & ~ref_d;

  // control pin role decode
  pin_role_e         role;
  logic              oe_off, pd_act;
  logic [BANK_W-1:0] req_bank;

  assign role = pin_role_e'(pin_role);

  always_comb begin
    oe_off   = 1'b0;
    pd_act   = 1'b0;
    req_bank = '0;
    unique case (role)
      ROLE_OE, ROLE_OE_ALT: oe_off   = !ctl_s;
      ROLE_PD:              pd_act   = !ctl_s;
      ROLE_BANK:            req_bank = BANK_W'(ctl_s);
      default:              oe_off   = 1'b0;
    endcase
  end

  // configuration banks
  bank_cfg_t         wr_cfg, act_cfg;
  logic [BANK_W-1:0] act_bank;

  assign wr_cfg = '{div:      cfg_wr_div,
                    main_sel: main_src_e'(cfg_wr_main_sel),
                    aux_sel:  aux_src_e'(cfg_wr_aux_sel)};

  rcs_cfg_banks #(.RST_CFG(RST_CFG)) u_banks (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_bank (BANK_W'(cfg_wr_bank)),
    .wr_cfg  (wr_cfg),
    .rd_bank (act_bank),
    .rd_cfg  (act_cfg)
  );

  // post divider
  logic             div_q, div_tc;
  logic [DIV_W-1:0] div_cnt;

  rcs_post_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (!pd_act),
    .ref_rise (ref_rise),
    .div      (act_cfg.div),
    .div_q    (div_q),
    .tc       (div_tc),
    .cnt      (div_cnt)
  );

  // bank change deferred to terminal count
  always_ff @(posedge clk) begin
    if (rst)         act_bank <= '0;
    else if (div_tc) act_bank <= req_bank;
  end

  // source steering
  logic main_src_w, aux_src_w, aux_copy;
  logic main_en, main_pass, aux_en, aux_pass;

  always_comb begin
    case (act_cfg.main_sel)
      MAIN_REF:  main_src_w = ref_s;
      MAIN_LOOP: main_src_w = loop_s;
      default:   main_src_w = div_q;
    endcase
  end

  assign aux_copy  = (act_cfg.aux_sel == AUX_MAIN);
  assign aux_src_w = aux_copy ? main_pass : ref_s;

  rcs_out_gate u_main_gate (
    .clk  (clk),
    .rst  (rst),
    .src  (main_src_w),
    .want (!pd_act && !oe_off),
    .en_q (main_en),
    .pass (main_pass),
    .out  (main_out)
  );

  rcs_out_gate u_aux_gate (
    .clk  (clk),
    .rst  (rst),
    .src  (aux_src_w),
    .want (!pd_act),
    .en_q (aux_en),
    .pass (aux_pass),
    .out  (aux_out)
  );
endmodule

// File: rtl/refclk_steer_chk.sv
module refclk_steer_chk
  import rcs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pd_act,
  input logic              div_q,
  input logic              div_tc,
  input logic [DIV_W-1:0]  div_cnt,
  input logic [BANK_W-1:0] act_bank,
  input logic              main_src,
  input logic              main_en,
  input logic              aux_src,
  input logic              aux_en,
  input logic              aux_copy,
  input logic              main_out,
  input logic              aux_out
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!main_out && !aux_out && act_bank == '0));

  a_r7_pd_clears_div: assert property (@(posedge clk) disable iff (rst)
    pd_act |=> (div_cnt == '0 && !div_q));

  a_r8_main_gate_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(main_en) |-> !$past(main_src));

  a_r8_aux_gate_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(aux_en) |-> !$past(aux_src));

  a_r10_bank_at_tc: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_bank) |-> $past(div_tc));

  a_r5_aux_copies_main: assert property (@(posedge clk) disable iff (rst)
    ($past(aux_copy) && $past(aux_en)) |-> (aux_out == main_out));
endmodule

bind refclk_steer refclk_steer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pd_act   (pd_act),
  .div_q    (div_q),
  .div_tc   (div_tc),
  .div_cnt  (div_cnt),
  .act_bank (act_bank),
  .main_src (main_src_w),
  .main_en  (main_en),
  .aux_src  (aux_src_w),
  .aux_en   (aux_en),
  .aux_copy (aux_copy),
  .main_out (main_out),
  .aux_out  (aux_out)
);

// File: tb/refclk_steer_bench.sv
module refclk_steer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HALF   = 4;   // reference period 8 clk
  localparam int LOOP_HALF  = 3;   // loop period 6 clk
  localparam int WIN        = 480; // multiple of every period used
  localparam int SETTLE     = 300;
  localparam int BIG        = 1000000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0, loop_in = 1'b0, ctl_pin = 1'b1;
  logic [1:0] pin_role = 2'd0;
  logic       cfg_wr_en = 1'b0, cfg_wr_bank = 1'b0, cfg_wr_aux_sel = 1'b0;
  logic [4:0] cfg_wr_div = 5'd0;
  logic [1:0] cfg_wr_main_sel = 2'd0;
  logic       main_out, aux_out;

  refclk_steer u_refclk_steer (
    .clk(clk), .rst(rst), .ref_in(ref_in), .loop_in(loop_in), .ctl_pin(ctl_pin),
    .pin_role(pin_role), .cfg_wr_en(cfg_wr_en), .cfg_wr_bank(cfg_wr_bank),
    .cfg_wr_div(cfg_wr_div), .cfg_wr_main_sel(cfg_wr_main_sel),
    .cfg_wr_aux_sel(cfg_wr_aux_sel), .main_out(main_out), .aux_out(aux_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin repeat (REF_HALF)  @(posedge clk); #1 ref_in  = ~ref_in;  end
  initial forever begin repeat (LOOP_HALF) @(posedge clk); #1 loop_in = ~loop_in; end

  int n_checks = 0, n_fail = 0;
  bit reported = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_range(input string tag, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // scoreboard
  typedef struct {
    string tag;
    int    e_main;
    int    e_aux;
    int    e_minh;
  } exp_t;
  exp_t sb[$];

  logic meas = 1'b0, meas_d = 1'b0, pm = 1'b0, pa = 1'b0;
  int   m_cnt, a_cnt, m_min, m_len;
  bit   m_run;

  always @(negedge clk) begin
    exp_t it;
    if (meas && !meas_d) begin
      m_cnt = 0; a_cnt = 0; m_min = BIG; m_len = 0; m_run = 1'b0;
    end
    if (meas) begin
      if (main_out && !pm) begin m_cnt++; m_run = 1'b1; m_len = 0; end
      if (main_out) m_len++;
      if (!main_out && pm && m_run) begin
        if (m_len < m_min) m_min = m_len;
        m_run = 1'b0;
      end
      if (aux_out && !pa) a_cnt++;
    end
    if (!meas && meas_d) begin
      if (sb.size() == 0) begin
        check("scoreboard empty", 1, 0);
      end else begin
        it = sb.pop_front();
        if (it.e_main >= 0) check({it.tag, " main rises"}, m_cnt, it.e_main);
        if (it.e_aux  >= 0) check({it.tag, " aux rises"},  a_cnt, it.e_aux);
        if (it.e_minh >= 0) check({it.tag, " main min high"}, m_min, it.e_minh);
      end
    end
    pm = main_out; pa = aux_out; meas_d = meas;
  end

  task automatic window(input string tag, input int e_main, input int e_aux, input int e_minh);
    exp_t it;
    it.tag = tag; it.e_main = e_main; it.e_aux = e_aux; it.e_minh = e_minh;
    sb.push_back(it);
    @(posedge clk); #1 meas = 1'b1;
    repeat (WIN) @(posedge clk);
    #1 meas = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic cfg(input bit bank, input int div, input int msel, input bit asel);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_wr_bank = bank; cfg_wr_div = 5'(div);
    cfg_wr_main_sel = 2'(msel); cfg_wr_aux_sel = asel;
    @(posedge clk); #1 cfg_wr_en = 1'b0;
  endtask

  task automatic pin(input int role, input bit lvl);
    @(posedge clk); #1 pin_role = 2'(role); ctl_pin = lvl;
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 main low in reset", int'(main_out), 0);
    check("R1 aux low in reset",  int'(aux_out),  0);
    @(posedge clk); #1 rst = 1'b0;
    settle();
    window("R1 reset defaults ref/ref", 60, 60, 4);

    cfg(0, 1, 1, 0); settle();
    window("R2 main=loop", 80, 60, 3);
    cfg(0, 3, 2, 0); settle();
    window("R3 div 3", 10, 60, 24);
    cfg(0, 15, 2, 0); settle();
    window("R3 div 15", 2, 60, 120);
    cfg(0, 2, 3, 0); settle();
    window("R2 code 3 div 2", 15, 60, 16);
    cfg(0, 0, 2, 0); settle();
    window("R4 div 0 as 1", 30, 60, 8);

    cfg(0, 1, 1, 1); settle();
    window("R5 aux copies loop main", 80, 80, 3);

    cfg(0, 1, 0, 1); pin(0, 0); settle();
    window("R6 oe low aux copy", 0, 0, -1);
    cfg(0, 1, 0, 0); settle();
    window("R6 oe low aux ref", 0, 60, -1);
    pin(3, 0); settle();
    window("R6 alt role oe low", 0, 60, -1);
    pin(0, 1); settle();
    window("R6 oe high resumes", 60, 60, 4);

    fork
      window("R8 oe toggling no runt", -1, 60, 4);
      begin
        repeat (36) begin
          repeat (13) @(posedge clk);
          #1 ctl_pin = ~ctl_pin;
        end
      end
    join
    pin(0, 1); settle();

    cfg(0, 5, 2, 0); pin(1, 0); settle();
    window("R7 power-down both low", 0, 0, -1);
    begin
      int lat = 0;
      pin(1, 1);
      while (!main_out && lat < 200) begin @(negedge clk); lat++; end
      check_range("R7 first divided rise after release", lat, 30, 48);
    end
    settle();

    cfg(0, 3, 2, 0); cfg(1, 1, 1, 1);
    pin(2, 0); settle();
    window("R9 bank 0", 10, 60, 24);
    pin(2, 1); settle();
    window("R9 bank 1", 80, 80, 3);

    cfg(1, 5, 2, 0); pin(2, 0); settle();
    fork
      window("R10 bank toggling no runt", -1, 60, 24);
      begin
        repeat (4) begin
          repeat (100) @(posedge clk);
          #1 ctl_pin = ~ctl_pin;
        end
      end
    join
    pin(2, 1); settle();
    window("R10 bank 1 after switch", 6, 60, 40);

    report();
  end
endmodule